// File: doc/BRIEF.md
# Monochrome-to-Color Pixel Expander

This block turns one byte of single-bit pixels into eight colored pixels and writes them into a byte-wide video memory port. Each pixel can be one, two, three or four bytes wide. Source bits are used most significant first. A 1 bit produces the foreground color. A 0 bit produces the background color in opaque mode. In transparent mode a 0 bit writes nothing, so the existing memory content stays and still takes its place in the address sequence.

Software sets up per-byte foreground and background colors through a small configuration port. It then presents a source byte, a destination address, a mode and a pixel depth on a strobe. The block masks the address to the video aperture. It accepts the strobe only for addresses inside the low memory window. It then emits one memory byte per clock, with a busy flag held high until all eight pixels are done. Strobes that arrive while busy are refused.

Top module: `mono_color_expander`

## Requirements
- R1: After reset `busy` and `mem_we` are low and every color register holds zero, so an opaque expansion issued right after reset writes only 0x00 bytes.
- R2: A strobe (`src_valid` high while `busy` is low, with an in-window address) is accepted at a rising edge. `busy` is high from the next cycle for exactly 8×B cycles, where B is bytes per pixel. Strobes presented while `busy` is high are ignored and do not change the output stream.
- R3: `src_addr` is reduced to its low 17 bits. If the reduced address is 0x10000 or above, the strobe is ignored: `busy` stays low and nothing is written.
- R4: Pixel n (n = 0..7) is taken from source bit 7−n, so the most significant bit is expanded first.
- R5: A 1 bit writes the foreground bytes of lanes 0..B−1 in that order, with lane 0 at the lowest address of the pixel.
- R6: When `src_opaque` is 1, a 0 bit writes the background bytes of lanes 0..B−1.
- R7: When `src_opaque` is 0, a 0 bit keeps `mem_we` low for all B byte slots of that pixel, while the address still advances through them.
- R8: `src_depth` selects the pixel width: 0 gives 1 byte, 1 gives 2, 2 gives 3, 3 gives 4.
- R9: In busy cycle k (k = 0..8B−1), `mem_addr` equals the reduced base address plus k. That is byte lane k mod B of pixel k div B, one byte per clock.
- R10: A configuration write with `cfg_we` high stores `cfg_data` into a color register. `cfg_sel[2]` picks foreground (1) or background (0), and `cfg_sel[1:0]` picks the byte lane. The value is used by expansions from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Color register write strobe |
| cfg_sel | input | 3 | Bit 2 foreground/background, bits 1:0 byte lane |
| cfg_data | input | 8 | Color byte to store |
| src_valid | input | 1 | Source byte strobe |
| src_byte | input | 8 | Eight one-bit pixels, MSB first |
| src_addr | input | 32 | Destination base address before masking |
| src_opaque | input | 1 | 1 = zero bits paint background, 0 = zero bits skipped |
| src_depth | input | 2 | Bytes per pixel minus one |
| busy | output | 1 | Expansion in progress, new strobes refused |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | 17 | Memory byte address |
| mem_data | output | 8 | Memory byte data |

## Verification
The bench targets the transparent-mode gap. There, a design that stops advancing the address on skipped pixels would shift every later pixel onto the wrong bytes. A design that writes anyway would overwrite memory it must leave alone. Lane ordering at 24 and 32 bits per pixel is checked byte by byte, because swapped lanes or a wrong lane count would mix colors or stretch the run beyond 8×B cycles. Addresses with bits set above bit 16 probe the masking. The window edge at 0x10000 probes acceptance, since an off-by-one compare would start writes outside video memory. Strobes held active during a run confirm that a busy expander neither restarts nor picks up new source bits.

// File: rtl/mcx_pkg.sv
package mcx_pkg;
   localparam int BYTE_W   = 8;
   localparam int SRC_BITS = 8;

   typedef enum logic [1:0] {
      DEPTH_8  = 2'd0,
      DEPTH_16 = 2'd1,
      DEPTH_24 = 2'd2,
      DEPTH_32 = 2'd3
   } depth_e;
endpackage

// File: rtl/mcx_window_filter.sv
module mcx_window_filter #(
   parameter int ADDR_IN_W = 32,
   parameter int MEM_AW    = 17,
   parameter int WINDOW_AW = 16
) (
   input  logic [ADDR_IN_W-1:0] addr_in,
   output logic [MEM_AW-1:0]    addr_masked,
   output logic                 in_window
);
   generate
      if (ADDR_IN_W > MEM_AW) begin : g_trunc
         logic unused_hi_bits;
         assign unused_hi_bits = ^addr_in[ADDR_IN_W-1:MEM_AW];
         assign addr_masked    = addr_in[MEM_AW-1:0];
      end else begin : g_extend
         assign addr_masked = MEM_AW'(addr_in);
      end
   endgenerate

   // The window is the lower part of the masked aperture
   assign in_window = ~|addr_masked[MEM_AW-1:WINDOW_AW];
endmodule

// File: rtl/mcx_color_bank.sv
module mcx_color_bank #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [$clog2(LANES):0]    cfg_sel,
   input  logic [BYTE_W-1:0]         cfg_data,
   output logic [LANES*BYTE_W-1:0]   fg_flat,
   output logic [LANES*BYTE_W-1:0]   bg_flat
);
   localparam int LANE_W = $clog2(LANES);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [BYTE_W-1:0] fg_q;
         logic [BYTE_W-1:0] bg_q;
         logic              hit;

         assign hit = cfg_we && (cfg_sel[LANE_W-1:0] == LANE_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fg_q <= '0;
               bg_q <= '0;
            end else if (hit) begin
               if (cfg_sel[LANE_W]) fg_q <= cfg_data;
               else                 bg_q <= cfg_data;
            end
         end

         assign fg_flat[g*BYTE_W +: BYTE_W] = fg_q;
         assign bg_flat[g*BYTE_W +: BYTE_W] = bg_q;
      end
   endgenerate
endmodule

// File: rtl/mcx_sequencer.sv
module mcx_sequencer #(
   parameter int SRC_BITS = 8,
   parameter int LANES    = 4,
   parameter int MEM_AW   = 17
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [SRC_BITS-1:0]        src_bits,
   input  logic [MEM_AW-1:0]          base,
   input  logic                       opaque,
   input  logic [$clog2(LANES)-1:0]   last_lane,
   output logic                       busy,
   output logic                       cur_bit,
   output logic                       opaque_q,
   output logic [$clog2(LANES)-1:0]   lane,
   output logic [MEM_AW-1:0]          cur_addr
);
   localparam int LANE_W = $clog2(LANES);
   localparam int PIX_W  = $clog2(SRC_BITS);
   localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(SRC_BITS - 1);

   logic                busy_q;
   logic [SRC_BITS-1:0] bits_q;
   logic [LANE_W-1:0]   lane_q;
   logic [LANE_W-1:0]   last_lane_q;
   logic [PIX_W-1:0]    pix_q;
   logic [MEM_AW-1:0]   addr_q;
   logic                opq_q;
   logic                pix_done;

   assign pix_done = (lane_q == last_lane_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         bits_q      <= '0;
         lane_q      <= '0;
         last_lane_q <= '0;
         pix_q       <= '0;
         addr_q      <= '0;
         opq_q       <= 1'b0;
      end else if (start) begin
         busy_q      <= 1'b1;
         bits_q      <= src_bits;
         lane_q      <= '0;
         last_lane_q <= last_lane;
         pix_q       <= '0;
         addr_q      <= base;
         opq_q       <= opaque;
      end else if (busy_q) begin
         addr_q <= addr_q + MEM_AW'(1);
         if (pix_done) begin
            lane_q <= '0;
            bits_q <= {bits_q[SRC_BITS-2:0], 1'b0};
            pix_q  <= pix_q + PIX_W'(1);
            if (pix_q == LAST_PIX) busy_q <= 1'b0;
         end else begin
            lane_q <= lane_q + LANE_W'(1);
         end
      end
   end

   assign busy     = busy_q;
   assign cur_bit  = bits_q[SRC_BITS-1];
   assign opaque_q = opq_q;
   assign lane     = lane_q;
   assign cur_addr = addr_q;
endmodule

// File: rtl/mono_color_expander.sv
module mono_color_expander #(
   parameter int ADDR_IN_W = 32,
   parameter int MEM_AW    = 17,
   parameter int WINDOW_AW = 16,
   parameter int LANES     = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [$clog2(LANES):0]       cfg_sel,
   input  logic [mcx_pkg::BYTE_W-1:0]   cfg_data,
   input  logic                         src_valid,
   input  logic [mcx_pkg::SRC_BITS-1:0] src_byte,
   input  logic [ADDR_IN_W-1:0]         src_addr,
   input  logic                         src_opaque,
   input  logic [$clog2(LANES)-1:0]     src_depth,
   output logic                         busy,
   output logic                         mem_we,
   output logic [MEM_AW-1:0]            mem_addr,
   output logic [mcx_pkg::BYTE_W-1:0]   mem_data
);
   import mcx_pkg::*;

   localparam int LANE_W = $clog2(LANES);

   generate
      if (MEM_AW <= WINDOW_AW) begin : g_bad_window
         $error("MEM_AW must exceed WINDOW_AW");
      end
      if (LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_lanes
         $error("LANES must be a power of two of at least 2");
      end
      if (ADDR_IN_W < WINDOW_AW) begin : g_bad_in
         $error("ADDR_IN_W must cover the window");
      end
   endgenerate

   logic [MEM_AW-1:0]       base_masked;
   logic                    base_ok;
   logic                    start;
   logic                    seq_busy;
   logic                    cur_bit;
   logic                    opaque_q;
   logic [LANE_W-1:0]       lane;
   logic [LANES*BYTE_W-1:0] fg_flat;
   logic [LANES*BYTE_W-1:0] bg_flat;

   mcx_window_filter #(
      .ADDR_IN_W (ADDR_IN_W),
      .MEM_AW    (MEM_AW),
      .WINDOW_AW (WINDOW_AW)
   ) u_filter (
      .addr_in     (src_addr),
      .addr_masked (base_masked),
      .in_window   (base_ok)
   );

   mcx_color_bank #(
      .LANES  (LANES),
      .BYTE_W (BYTE_W)
   ) u_colors (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_data (cfg_data),
      .fg_flat  (fg_flat),
      .bg_flat  (bg_flat)
   );

   assign start = src_valid && base_ok && !seq_busy;

   mcx_sequencer #(
      .SRC_BITS (SRC_BITS),
      .LANES    (LANES),
      .MEM_AW   (MEM_AW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .src_bits  (src_byte),
      .base      (base_masked),
      .opaque    (src_opaque),
      .last_lane (src_depth),
      .busy      (seq_busy),
      .cur_bit   (cur_bit),
      .opaque_q  (opaque_q),
      .lane      (lane),
      .cur_addr  (mem_addr)
   );

   assign busy     = seq_busy;
   assign mem_we   = seq_busy && (cur_bit || opaque_q);
   assign mem_data = cur_bit ? fg_flat[lane*BYTE_W +: BYTE_W]
                             : bg_flat[lane*BYTE_W +: BYTE_W];
endmodule

// File: rtl/mcx_checker.sv
module mcx_checker #(
   parameter int MEM_AW    = 17,
   parameter int WINDOW_AW = 16,
   parameter int SRC_BITS  = 8,
   parameter int LANES     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              src_valid,
   input logic              busy,
   input logic              mem_we,
   input logic [MEM_AW-1:0] mem_addr
);
   localparam int RUN_MAX = SRC_BITS * LANES;
   localparam int RUN_W   = $clog2(RUN_MAX + 1) + 1;

   logic [RUN_W-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + RUN_W'(1);
      else           run_len <= '0;
   end

   // R2: writes happen only inside a run
   p_write_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   // R2: a run only starts from a strobe
   p_run_from_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(src_valid));

   // R3: the first address of a run lies in the window
   p_first_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (mem_addr >> WINDOW_AW) == '0);

   // R9: one byte address per clock
   p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> mem_addr == $past(mem_addr) + MEM_AW'(1));

   // R8: run length is eight pixels of a legal width
   p_run_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len != '0 && run_len <= RUN_W'(RUN_MAX)
                       && (run_len % RUN_W'(SRC_BITS)) == '0));
endmodule

bind mono_color_expander mcx_checker #(
   .MEM_AW    (MEM_AW),
   .WINDOW_AW (WINDOW_AW),
   .SRC_BITS  (mcx_pkg::SRC_BITS),
   .LANES     (LANES)
) u_mcx_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_valid (src_valid),
   .busy      (busy),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/mono_color_expander_test.sv
module mono_color_expander_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [7:0]  cfg_data = '0;
   logic        src_valid = 1'b0;
   logic [7:0]  src_byte = '0;
   logic [31:0] src_addr = '0;
   logic        src_opaque = 1'b0;
   logic [1:0]  src_depth = '0;
   logic        busy;
   logic        mem_we;
   logic [16:0] mem_addr;
   logic [7:0]  mem_data;

   int checks = 0;
   int fails  = 0;
   logic [7:0] fg_m [4];
   logic [7:0] bg_m [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   mono_color_expander uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .src_valid(src_valid), .src_byte(src_byte),
      .src_addr(src_addr), .src_opaque(src_opaque), .src_depth(src_depth),
      .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic exp_we(input logic [7:0] b, input bit opq,
                                   input int bpp, input int k);
      logic bit_v = b[7 - k / bpp];
      return bit_v | opq;
   endfunction

   function automatic logic [7:0] exp_data(input logic [7:0] b, input int bpp,
                                           input int k);
      int lane = k % bpp;
      return b[7 - k / bpp] ? fg_m[lane] : bg_m[lane];
   endfunction

   task automatic set_color(input bit fg, input int lane, input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = {fg, 2'(lane)}; cfg_data = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (fg) fg_m[lane] = v; else bg_m[lane] = v;
   endtask

   // R2 R4 R5 R6 R7 R8 R9: full expansion, optional junk strobes while busy
   task automatic expand(input logic [7:0] b, input logic [31:0] a, input bit opq,
                         input int depth, input bit junk, input string req);
      int bpp = depth + 1;
      logic [16:0] base = a[16:0];
      @(negedge clk);
      src_valid = 1'b1; src_byte = b; src_addr = a; src_opaque = opq;
      src_depth = 2'(depth);
      @(posedge clk);
      for (int k = 0; k < 8 * bpp; k++) begin
         @(negedge clk);
         check(busy == 1'b1, {req, " R2 busy"}, 32'(busy), 32'd1);
         check(mem_we == exp_we(b, opq, bpp, k), {req, " R7 we"},
               32'(mem_we), 32'(exp_we(b, opq, bpp, k)));
         check(mem_addr == base + 17'(k), {req, " R9 addr"},
               32'(mem_addr), 32'(base + 17'(k)));
         if (exp_we(b, opq, bpp, k))
            check(mem_data == exp_data(b, bpp, k), {req, " R5 data"},
                  32'(mem_data), 32'(exp_data(b, bpp, k)));
         if (junk && k < 8 * bpp - 1) begin
            src_byte = 8'($urandom); src_opaque = ~opq;
            src_depth = 2'($urandom); src_addr = 32'($urandom) & 32'h0000_FFFF;
         end else begin
            src_valid = 1'b0;
         end
      end
      @(negedge clk);
      check(busy == 1'b0, {req, " R2 busy end"}, 32'(busy), 32'd0);
      check(mem_we == 1'b0, {req, " R2 we end"}, 32'(mem_we), 32'd0);
      src_valid = 1'b0;
   endtask

   // R3: out-of-window strobe must be ignored
   task automatic reject(input logic [31:0] a);
      @(negedge clk);
      src_valid = 1'b1; src_byte = 8'hFF; src_addr = a; src_opaque = 1'b1;
      src_depth = 2'd3;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(busy == 1'b0, "R3 reject busy", 32'(busy), 32'd0);
         check(mem_we == 1'b0, "R3 reject we", 32'(mem_we), 32'd0);
      end
      src_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual %0d expected done", WATCHDOG);
      finish_run();
   end

   initial begin
      void'($urandom(32'h0C0F_FEE5));
      for (int i = 0; i < 4; i++) begin fg_m[i] = '0; bg_m[i] = '0; end
      repeat (3) @(negedge clk);
      // R1: state during and after reset
      check(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
      check(mem_we == 1'b0, "R1 we", 32'(mem_we), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R1 busy after", 32'(busy), 32'd0);
      // R1: zero colors after reset, opaque 32 bpp
      expand(8'hA5, 32'h0000_0040, 1'b1, 3, 1'b0, "R1 zero colors");

      // R10: program distinct colors per lane
      for (int l = 0; l < 4; l++) begin
         set_color(1'b1, l, 8'(8'hF0 + l));
         set_color(1'b0, l, 8'(8'h10 + l));
      end
      // R4 R5: MSB-first order, single set bit, 8 bpp
      expand(8'h80, 32'h0000_0100, 1'b0, 0, 1'b0, "R4 msb");
      expand(8'h01, 32'h0000_0200, 1'b1, 0, 1'b0, "R4 lsb");
      // R6 R8: opaque at 16 and 24 bpp
      expand(8'h5A, 32'h0000_1000, 1'b1, 1, 1'b0, "R6 16bpp");
      expand(8'hC3, 32'h0000_2000, 1'b1, 2, 1'b0, "R6 24bpp");
      // R7: transparent, all zeros and all ones at 32 bpp
      expand(8'h00, 32'h0000_3000, 1'b0, 3, 1'b0, "R7 all zero");
      expand(8'hFF, 32'h0000_4000, 1'b0, 3, 1'b0, "R7 all one");
      // R3: high bits masked away, window top edge
      expand(8'h96, 32'hFFFE_0123, 1'b1, 1, 1'b0, "R3 mask");
      expand(8'h69, 32'h0000_FFFF, 1'b1, 3, 1'b0, "R3 edge");
      reject(32'h0001_0000);
      reject(32'hABC1_2345);
      // R2: strobes while busy are ignored
      expand(8'h3C, 32'h0000_5000, 1'b0, 2, 1'b1, "R2 junk");
      // R10: recolor one lane, takes effect next run
      set_color(1'b1, 2, 8'h77);
      expand(8'hF0, 32'h0000_6000, 1'b1, 2, 1'b0, "R10 recolor");

      for (int n = 0; n < 40; n++) begin
         if (n % 8 == 0) set_color(1'($urandom), int'($urandom % 4), 8'($urandom));
         expand(8'($urandom), 32'($urandom) & 32'hFFFE_FFFF,
                1'($urandom), int'($urandom % 4), 1'($urandom), "R9 random");
      end
      finish_run();
   end
endmodule